// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software timing with a 7-bit down-counter that must be reloaded inside a permitted window. Once software arms it, the counter steps down once per tick. The tick comes from the bus clock divided by a fixed power of two and then by a selectable factor of 1, 2, 4 or 8. The block raises a one-cycle reset request to the system reset controller in three cases: the count falls out of its upper half (0x40 to 0x3F), software reloads it while the count is still above the programmed window value, or software loads a value whose bit 6 is clear while the timer is armed.

Software reaches the block through three plain write strobes that share one data bus, and reads each register directly from an output port. An optional early-warning interrupt flags the tick on which the count reaches 0x40, one tick before the timeout. The arm bit and the early-warning enable can only be set. Only the block's own reset clears them.

Top module: `win_wdog`

## Requirements
- R1: After reset the control readback is 0x7F (count 0x7F, not armed), the configuration readback is 0x07F (window 0x7F, divider select 0, warning enable 0), and the status flag, interrupt and reset request are all 0.
- R2: While not armed, the count does not change, and no reset request is raised unless a control write arms the block. A control write with bit 7 clear loads bits 6:0 into the count with no window check.
- R3: A control write with bit 7 set arms the block. Control writes with bit 7 clear never disarm it.
- R4: While armed, the count decrements every 2^PRE_LOG2 × 2^S bus cycles, where S is configuration bits 8:7. Every control write restarts this interval from zero.
- R5: When an armed count steps from 0x40 to 0x3F, a reset request is raised.
- R6: A control write while armed raises a reset request when the current count is greater than the window value in configuration bits 6:0. No request is raised when the count is equal to or below the window value.
- R7: A control write that leaves the block armed and whose bit 6 is clear raises a reset request.
- R8: The status flag (bit 0) sets on the tick that brings the count to 0x40. The interrupt output equals the flag ANDed with the warning enable in configuration bit 9.
- R9: Configuration bit 9 can be set by a configuration write but is never cleared by one.
- R10: A status write with data bit 0 equal to 0 clears the flag. A status write with bit 0 equal to 1 leaves the flag unchanged.
- R11: The reset request is registered and lasts exactly one cycle. It is high in the cycle after the clock edge that samples its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ctrl | input | 1 | Control write strobe: bits 6:0 count, bit 7 arm |
| wr_cfg | input | 1 | Configuration write strobe: bits 6:0 window, 8:7 divider select, 9 warning enable |
| wr_stat | input | 1 | Status write strobe: bit 0 written as 0 clears the flag |
| wdata | input | 10 | Write data shared by all strobes |
| ctrl_q | output | 8 | Control readback {armed, count} |
| cfg_q | output | 10 | Configuration readback |
| stat_q | output | 1 | Early-warning flag |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Write strobes are sampled on one rising edge. The register readbacks and any reset request caused by the write are due half a cycle later, and the bench reads them at the following falling edge. A tick lands exactly P = 2^PRE_LOG2 × 2^S edges after the last control write. The bench counts falling edges from that write and expects the count to be the loaded value minus floor(m/P) after m edges. Window decisions are predicted from the count read just before the reload. Underflow, flag and interrupt timing are checked on the exact edges where the count passes 0x41, 0x40 and 0x3F.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_W  = 7;
  localparam int SEL_W  = 2;
  localparam int DATA_W = 10;

  localparam logic [CNT_W-1:0] CNT_WARN = 7'h41;
  localparam logic [CNT_W-1:0] CNT_LAST = 7'h40;
  localparam logic [CNT_W-1:0] CNT_INIT = 7'h7F;

  typedef struct packed {
    logic             warn_en;
    logic [SEL_W-1:0] div_sel;
    logic [CNT_W-1:0] window;
  } wdg_cfg_t;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
  import wdg_pkg::*;
#(
  parameter int PRE_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL = 1 << SEL_W;
  localparam int PW   = PRE_LOG2 + NSEL - 1;

  logic [PW-1:0] lim [NSEL];
  logic [PW-1:0] pre_q, pre_d;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim[g] = {PW{1'b1}} >> (NSEL - 1 - g);
  end

  assign tick = run && !restart && (pre_q == lim[sel]);

  always_comb begin
    if (!run || restart || tick) pre_d = '0;
    else                         pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             ld_arm,
  input  logic [CNT_W-1:0] window,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             armed_q,
  output logic             req_q,
  output logic             warn_evt
);
  logic [CNT_W-1:0] cnt_d;
  logic             armed_d, req_d;
  logic             early, low_load, underflow;

  assign armed_d   = armed_q | (ld & ld_arm);
  assign early     = ld & armed_q & (cnt_q > window);
  assign low_load  = ld & armed_d & ~ld_val[CNT_W-1];
  assign underflow = tick & (cnt_q == CNT_LAST);
  assign warn_evt  = tick & (cnt_q == CNT_WARN);
  assign req_d     = early | low_load | underflow;

  always_comb begin
    if (ld)        cnt_d = ld_val;
    else if (tick) cnt_d = cnt_q - 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_INIT;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      req_q   <= req_d;
    end
  end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              warn_evt,
  output wdg_cfg_t          cfg_q,
  output logic              flag_q,
  output logic              irq
);
  wdg_cfg_t cfg_d;
  logic     flag_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_cfg) begin
      cfg_d.window  = wdata[CNT_W-1:0];
      cfg_d.div_sel = wdata[CNT_W+SEL_W-1:CNT_W];
      cfg_d.warn_en = cfg_q.warn_en | wdata[CNT_W+SEL_W];
    end
    flag_d = warn_evt | (flag_q & ~(wr_stat & ~wdata[0]));
  end

  assign irq = flag_q & cfg_q.warn_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.window  <= CNT_INIT;
      cfg_q.div_sel <= '0;
      cfg_q.warn_en <= 1'b0;
      flag_q        <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import wdg_pkg::*;
#(
  parameter int PRE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_cfg,
  input  logic        wr_stat,
  input  logic [9:0]  wdata,
  output logic [7:0]  ctrl_q,
  output logic [9:0]  cfg_q,
  output logic        stat_q,
  output logic        irq,
  output logic        rst_req
);
  wdg_cfg_t         cfg;
  logic [CNT_W-1:0] cnt;
  logic             armed, tick, warn_evt;

  wdg_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(armed), .restart(wr_ctrl),
    .sel(cfg.div_sel), .tick(tick)
  );

  wdg_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(wr_ctrl), .ld_val(wdata[CNT_W-1:0]),
    .ld_arm(wdata[CNT_W]), .window(cfg.window), .tick(tick),
    .cnt_q(cnt), .armed_q(armed), .req_q(rst_req), .warn_evt(warn_evt)
  );

  wdg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_stat(wr_stat),
    .wdata(wdata), .warn_evt(warn_evt), .cfg_q(cfg), .flag_q(stat_q),
    .irq(irq)
  );

  assign ctrl_q = {armed, cnt};
  assign cfg_q  = cfg;
endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ctrl,
  input logic       tick,
  input logic [7:0] ctrl_q,
  input logic [9:0] cfg_q,
  input logic       stat_q,
  input logic       rst_req
);
  // R3
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] |=> ctrl_q[7]);
  // R9
  warn_en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[9] |=> cfg_q[9]);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[7] && !wr_ctrl) |=> $stable(ctrl_q[6:0]));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[7] && !wr_ctrl) |=> !rst_req);
  // R5
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl_q[6:0] == 7'h40) |=> (rst_req && ctrl_q[6:0] == 7'h3F));
  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> (ctrl_q[6:0] == 7'h40));
  // R11
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
endmodule

bind win_wdog win_wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .tick(tick),
  .ctrl_q(ctrl_q), .cfg_q(cfg_q), .stat_q(stat_q), .rst_req(rst_req)
);

// File: tb/tb_win_wdog.sv
module tb_win_wdog;
  localparam int PL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_ctrl = 1'b0, wr_cfg = 1'b0, wr_stat = 1'b0;
  logic [9:0] wdata = '0;
  logic [7:0] ctrl_q;
  logic [9:0] cfg_q;
  logic       stat_q, irq, rst_req;
  int         checks = 0, errs = 0, pulses = 0;

  win_wdog #(.PRE_LOG2(PL)) dut (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_cfg(wr_cfg),
    .wr_stat(wr_stat), .wdata(wdata), .ctrl_q(ctrl_q), .cfg_q(cfg_q),
    .stat_q(stat_q), .irq(irq), .rst_req(rst_req)
  );

  always #5 clk = ~clk;
  always @(negedge clk) if (rst_n && rst_req) pulses++;

  function automatic int per(int s);
    return (1 << PL) << s;
  endfunction

  function automatic int exp_count(int c, int m, int s);
    return c - m / per(s);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic eq(string req, int act, int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; wr_ctrl = 0; wr_cfg = 0; wr_stat = 0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wctrl(logic [7:0] v);
    wdata = {2'b00, v}; wr_ctrl = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_ctrl = 1'b0;
  endtask

  task automatic wcfg(logic [9:0] v);
    wdata = v; wr_cfg = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_cfg = 1'b0;
  endtask

  task automatic wstat(logic [9:0] v);
    wdata = v; wr_stat = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_stat = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    eq("R1 ctrl", ctrl_q, 8'h7F);
    eq("R1 cfg", cfg_q, 10'h07F);
    eq("R1 flag", stat_q, 0);
    eq("R1 irq", irq, 0);
    eq("R1 req", rst_req, 0);

    // R2 idle: no counting, unchecked loads
    wait_n(200);
    eq("R2 idle hold", ctrl_q, 8'h7F);
    wcfg(10'h045);
    wctrl(8'h35);
    eq("R2 idle load", ctrl_q, 8'h35);
    wctrl(8'h7A);
    eq("R2 idle load above window", ctrl_q, 8'h7A);
    wait_n(100);
    eq("R2 idle no request", pulses, 0);

    // R4 tick period per divider, R3 sticky arm, R4 restart on reload
    for (int s = 0; s < 4; s++) begin
      do_reset();
      wcfg({1'b0, s[1:0], 7'h7F});
      wctrl(8'hFF);
      wait_n(per(s) - 1);
      eq("R4 before tick", ctrl_q, 8'hFF);
      wait_n(1);
      eq("R4 after tick", ctrl_q, 8'hFE);
      wctrl(8'h70);
      eq("R3 arm kept", ctrl_q, 8'hF0);
      wait_n(per(s) - 1);
      wctrl(8'h70);
      wait_n(per(s) - 1);
      eq("R4 restart", ctrl_q, 8'hF0);
      wait_n(1);
      eq("R4 restart tick", ctrl_q, 8'hEF);
    end

    // R8 warning, R10 flag clear, R5 underflow, R11 pulse, R9 sticky enable
    do_reset();
    wcfg(10'h27F);
    wctrl(8'hC2);
    wait_n(31);
    eq("R8 count 41", ctrl_q, 8'hC1);
    eq("R8 flag low", stat_q, 0);
    wait_n(1);
    eq("R8 count 40", ctrl_q, 8'hC0);
    eq("R8 flag set", stat_q, 1);
    eq("R8 irq", irq, 1);
    wstat(10'h001);
    eq("R10 write one keeps", stat_q, 1);
    wait_n(14);
    eq("R5 no early timeout", rst_req, 0);
    wait_n(1);
    eq("R5 timeout", rst_req, 1);
    eq("R5 count 3F", ctrl_q, 8'hBF);
    wait_n(1);
    eq("R11 one cycle", rst_req, 0);
    wstat(10'h000);
    eq("R10 cleared", stat_q, 0);
    eq("R8 irq follows", irq, 0);
    wcfg(10'h07F);
    eq("R9 enable sticky", cfg_q, 10'h27F);

    // R8 irq masked when enable clear
    do_reset();
    wctrl(8'hC1);
    wait_n(16);
    eq("R8 flag no enable", stat_q, 1);
    eq("R8 irq masked", irq, 0);

    // R7 low loads
    do_reset();
    wctrl(8'hBF);
    eq("R7 arm with low value", rst_req, 1);
    do_reset();
    wctrl(8'hFF);
    wctrl(8'hA0);
    eq("R7 armed low reload", rst_req, 1);

    // R6 window boundary
    do_reset();
    wcfg(10'h050);
    wctrl(8'hD1);
    eq("R6 arming unchecked", rst_req, 0);
    wait_n(16);
    wctrl(8'hFF);
    eq("R6 equal to window", rst_req, 0);
    do_reset();
    wcfg(10'h050);
    wctrl(8'hD1);
    wait_n(15);
    wctrl(8'hFF);
    eq("R6 one above window", rst_req, 1);

    // R6 R4 random trials
    for (int t = 0; t < 24; t++) begin
      int c, s, w, m, lim, cur;
      c = 'h41 + int'($urandom_range(62));
      s = int'($urandom_range(3));
      w = 'h40 + int'($urandom_range(63));
      lim = (c - 'h40) * per(s);
      if (lim > 1500) lim = 1500;
      m = int'($urandom_range(lim - 1));
      do_reset();
      wcfg({1'b0, s[1:0], w[6:0]});
      wctrl({1'b1, c[6:0]});
      wait_n(m);
      cur = exp_count(c, m, s);
      eq("R4 random count", ctrl_q, 'h80 | cur);
      wctrl(8'hFF);
      eq("R6 random refresh", rst_req, (cur > w) ? 1 : 0);
    end

    summary();
  end
endmodule